// File: doc/BRIEF.md
# Parallel NOR Flash Identification Probe

The probe runs once after a start pulse. It finds out which parallel NOR flash bank sits on a word-wide bus. It drives a simple bus master port (address, write data, write strobe, read strobe, read data, acknowledge) and issues the identify command sequence. That sequence works for both the AMD-style and the Intel-style vendor families. The probe then reads back the manufacturer and device codes.

From those two codes it classifies the vendor family and looks the device up in a parameter table. It reports the sector count and the bank size in bytes. A recognised part is then put back into read mode with the command its family expects. An unrecognised part is reported as unknown, with zero sectors and zero size.

System logic uses the probe at boot to size the flash region before any erase or program driver runs. Bus electrical timing is left to the bus slave, which only has to answer each strobe with a one-cycle acknowledge.

Top module: `flash_id_probe`

## Requirements
- R1: When start is seen in idle, the probe issues three writes in this order: 0xAA to unlock offset A, 0x55 to unlock offset B, then 0x90 to unlock offset A. Each command byte is copied into every byte lane of the data word. Offsets A/B are 0x555/0x2AA, or 0x554/0x2AB when SWAP_ADDR=1.
- R2: Only one strobe is active at a time. Once a strobe is raised, the strobe, the address and the write data stay unchanged until the cycle in which bus_ack is high. The next access starts only after that cycle.
- R3: After the three writes, the probe reads word offset 1 (manufacturer) and then word offset 0 (device).
- R4: The family is taken from bits [7:0] of the offset-1 word alone: AMD_CODE (default 0x01) gives family 1, INTEL_CODE (default 0x89) gives family 2, and any other value gives family 0. Bits above bit 7 have no effect.
- R5: The offset-0 word is compared at full bus width against each table code, copied into every 16-bit half of the word. The default table maps 0x22D7→128 sectors/8 MiB, 0x88C1→23/1 MiB, 0x88C3→39/2 MiB, 0x88C5→71/4 MiB and 0x88CD→135/8 MiB (sizes given for a 16-bit bus).
- R6: The reported bank size is the table size multiplied by DATA_W/16: ×1 on a 16-bit bus and ×2 on a 32-bit bus.
- R7: If either code is unrecognised, the probe reports family 0, sector_count 0 and bank_size 0, and issues no fourth write.
- R8: For a recognised part, a fourth write goes to offset 0 carrying 0xF0 (family 1) or 0xFF (family 2), copied into every byte lane.
- R9: After the last access, busy falls and done rises. done and the results hold until the next accepted start, which clears done in the same edge.
- R10: A start pulse that arrives while busy has no effect on the access sequence or on the results.
- R11: After reset: no strobe, busy=0, done=0, and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run the probe |
| bus_addr | output | ADDR_W | Word offset of the current access |
| bus_wdata | output | DATA_W | Write data |
| bus_we | output | 1 | Write strobe, held until acknowledge |
| bus_re | output | 1 | Read strobe, held until acknowledge |
| bus_rdata | input | DATA_W | Read data, sampled with acknowledge |
| bus_ack | input | 1 | Access complete |
| busy | output | 1 | Probe in progress |
| done | output | 1 | Results valid; held until next start |
| family | output | 2 | 0 unknown, 1 AMD-style, 2 Intel-style |
| man_code | output | 8 | Captured manufacturer byte |
| dev_code | output | DATA_W | Captured device word |
| sector_count | output | SECT_W | Sectors in the bank, 0 if unknown |
| bank_size | output | 32 | Bank size in bytes, 0 if unknown |

## Verification
Some rules must hold on every cycle, and the assertions cover those. They check the bus handshake: a single strobe, with address and data held until acknowledge. They also check that an exit command only ever carries 0xF0 or 0xFF, that an unknown result is always zeroed, that done holds steady, and that a start while busy never re-enters the first unlock step. Other behaviour shows only in the directed scenarios: the exact order, offsets and lane-copied data of the writes, the low-byte-only manufacturer compare, the full-width device compare on the 32-bit instance, the size doubling, and the missing fourth write for unknown parts.

// File: rtl/flash_probe_pkg.sv
package flash_probe_pkg;

  typedef enum logic [1:0] {
    FAM_NONE  = 2'd0,
    FAM_AMD   = 2'd1,
    FAM_INTEL = 2'd2
  } fam_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_IDENT,
    ST_RD_MAN,
    ST_RD_DEV,
    ST_EVAL,
    ST_EXIT
  } step_e;

  localparam logic [7:0] CMD_UNLOCK_A   = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK_B   = 8'h55;
  localparam logic [7:0] CMD_IDENT      = 8'h90;
  localparam logic [7:0] CMD_EXIT_AMD   = 8'hF0;
  localparam logic [7:0] CMD_EXIT_INTEL = 8'hFF;

  // Bytes in the bank: 2^lg for one 16-bit chip, times 2^chip_shift chips
  function automatic logic [31:0] bank_bytes(input logic [4:0] lg,
                                             input logic [1:0] chip_shift);
    logic [5:0] total;
    total = {1'b0, lg} + {4'b0, chip_shift};
    return 32'd1 << total;
  endfunction

  // Vendor family from the manufacturer byte
  function automatic fam_e family_of(input logic [7:0] code,
                                     input logic [7:0] amd_code,
                                     input logic [7:0] intel_code);
    if (code == amd_code)   return FAM_AMD;
    if (code == intel_code) return FAM_INTEL;
    return FAM_NONE;
  endfunction

endpackage

// File: rtl/probe_seq.sv
module probe_seq
  import flash_probe_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16,
  parameter bit SWAP_ADDR = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              bus_ack,
  input  logic              id_known,
  input  fam_e              fam_q,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  output logic              start_acc,
  output logic              cap_man,
  output logic              cap_dev,
  output logic              eval_now,
  output logic              finish,
  output logic              busy
);
  localparam int LANES = DATA_W / 8;
  localparam logic [ADDR_W-1:0] OFS_A = SWAP_ADDR ? ADDR_W'(12'h554) : ADDR_W'(12'h555);
  localparam logic [ADDR_W-1:0] OFS_B = SWAP_ADDR ? ADDR_W'(12'h2AB) : ADDR_W'(12'h2AA);

  step_e state, state_nx;
  logic [7:0] cmd_byte;
  logic exit_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nx;
  end

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:   if (start)   state_nx = ST_UNL1;
      ST_UNL1:   if (bus_ack) state_nx = ST_UNL2;
      ST_UNL2:   if (bus_ack) state_nx = ST_IDENT;
      ST_IDENT:  if (bus_ack) state_nx = ST_RD_MAN;
      ST_RD_MAN: if (bus_ack) state_nx = ST_RD_DEV;
      ST_RD_DEV: if (bus_ack) state_nx = ST_EVAL;
      ST_EVAL:   state_nx = id_known ? ST_EXIT : ST_IDLE;
      ST_EXIT:   if (bus_ack) state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_comb begin
    bus_we   = 1'b0;
    bus_re   = 1'b0;
    bus_addr = '0;
    cmd_byte = 8'h00;
    case (state)
      ST_UNL1:   begin bus_we = 1'b1; bus_addr = OFS_A; cmd_byte = CMD_UNLOCK_A; end
      ST_UNL2:   begin bus_we = 1'b1; bus_addr = OFS_B; cmd_byte = CMD_UNLOCK_B; end
      ST_IDENT:  begin bus_we = 1'b1; bus_addr = OFS_A; cmd_byte = CMD_IDENT;    end
      ST_RD_MAN: begin bus_re = 1'b1; bus_addr = ADDR_W'(1); end
      ST_RD_DEV: begin bus_re = 1'b1; bus_addr = '0; end
      ST_EXIT:   begin
        bus_we   = 1'b1;
        bus_addr = '0;
        cmd_byte = (fam_q == FAM_INTEL) ? CMD_EXIT_INTEL : CMD_EXIT_AMD;
      end
      default: ;
    endcase
  end

  // Copy the command byte into every lane of the bus word
  always_comb begin
    for (int i = 0; i < LANES; i++) bus_wdata[i*8 +: 8] = cmd_byte;
  end

  assign start_acc  = (state == ST_IDLE) && start;
  assign cap_man    = (state == ST_RD_MAN) && bus_ack;
  assign cap_dev    = (state == ST_RD_DEV) && bus_ack;
  assign eval_now   = (state == ST_EVAL);
  assign exit_phase = (state == ST_EXIT);
  assign finish     = (eval_now && !id_known) || (exit_phase && bus_ack);
  assign busy       = (state != ST_IDLE);

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_re)); // R2
  AST_HOLD_TO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we || bus_re) && !bus_ack |=> (bus_we == $past(bus_we)) && (bus_re == $past(bus_re))
      && $stable(bus_addr) && $stable(bus_wdata)); // R2
  AST_EXIT_CMD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    exit_phase |-> bus_we && (bus_wdata[7:0] == CMD_EXIT_AMD || bus_wdata[7:0] == CMD_EXIT_INTEL)); // R8
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && (state != ST_UNL1) |=> state != ST_UNL1); // R10

endmodule

// File: rtl/probe_classify.sv
module probe_classify
  import flash_probe_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int SECT_W  = 8,
  parameter int NUM_DEV = 5,
  parameter logic [7:0] AMD_CODE   = 8'h01,
  parameter logic [7:0] INTEL_CODE = 8'h89,
  parameter logic [NUM_DEV-1:0][15:0]       DEV_CODE = '0,
  parameter logic [NUM_DEV-1:0][SECT_W-1:0] DEV_SECT = '0,
  parameter logic [NUM_DEV-1:0][4:0]        DEV_LOG2 = '0
) (
  input  logic [7:0]        man_code,
  input  logic [DATA_W-1:0] dev_code,
  output logic              id_known,
  output fam_e              fam_c,
  output logic [SECT_W-1:0] sect_c,
  output logic [31:0]       size_c
);
  localparam int CHIPS = DATA_W / 16;
  localparam logic [1:0] CHIP_SHIFT = 2'($clog2(CHIPS));

  fam_e              fam_raw;
  logic              hit;
  logic [SECT_W-1:0] sect_hit;
  logic [4:0]        lg_hit;
  logic [DATA_W-1:0] expect_word;

  assign fam_raw = family_of(man_code, AMD_CODE, INTEL_CODE);

  always_comb begin
    hit         = 1'b0;
    sect_hit    = '0;
    lg_hit      = '0;
    expect_word = '0;
    for (int d = 0; d < NUM_DEV; d++) begin
      for (int c = 0; c < CHIPS; c++) expect_word[c*16 +: 16] = DEV_CODE[d];
      if (!hit && dev_code == expect_word) begin
        hit      = 1'b1;
        sect_hit = DEV_SECT[d];
        lg_hit   = DEV_LOG2[d];
      end
    end
  end

  assign id_known = hit && (fam_raw != FAM_NONE);
  assign fam_c    = id_known ? fam_raw : FAM_NONE;
  assign sect_c   = id_known ? sect_hit : '0;
  assign size_c   = id_known ? bank_bytes(lg_hit, CHIP_SHIFT) : 32'd0;

endmodule

// File: rtl/probe_result.sv
module probe_result
  import flash_probe_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int SECT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_acc,
  input  logic              cap_man,
  input  logic              cap_dev,
  input  logic              eval_now,
  input  logic              finish,
  input  logic [DATA_W-1:0] bus_rdata,
  input  fam_e              fam_c,
  input  logic [SECT_W-1:0] sect_c,
  input  logic [31:0]       size_c,
  output logic [7:0]        man_q,
  output logic [DATA_W-1:0] dev_q,
  output fam_e              fam_q,
  output logic [SECT_W-1:0] sect_q,
  output logic [31:0]       size_q,
  output logic              done_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      man_q  <= '0;
      dev_q  <= '0;
      fam_q  <= FAM_NONE;
      sect_q <= '0;
      size_q <= '0;
      done_q <= 1'b0;
    end else begin
      if (start_acc) begin
        man_q  <= '0;
        dev_q  <= '0;
        fam_q  <= FAM_NONE;
        sect_q <= '0;
        size_q <= '0;
        done_q <= 1'b0;
      end
      if (cap_man) man_q <= bus_rdata[7:0];
      if (cap_dev) dev_q <= bus_rdata;
      if (eval_now) begin
        fam_q  <= fam_c;
        sect_q <= sect_c;
        size_q <= size_c;
      end
      if (finish) done_q <= 1'b1;
    end
  end

  AST_UNKNOWN_ZEROED: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && (fam_q == FAM_NONE) |-> (sect_q == '0) && (size_q == '0)); // R7
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    done_q && !start_acc |=> done_q && $stable(sect_q) && $stable(size_q) && $stable(fam_q)); // R9

endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
  import flash_probe_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 16,
  parameter bit SWAP_ADDR = 1'b0,
  parameter int SECT_W    = 8,
  parameter int NUM_DEV   = 5,
  parameter logic [7:0] AMD_CODE   = 8'h01,
  parameter logic [7:0] INTEL_CODE = 8'h89,
  parameter logic [NUM_DEV-1:0][15:0] DEV_CODE =
    {16'h88CD, 16'h88C5, 16'h88C3, 16'h88C1, 16'h22D7},
  parameter logic [NUM_DEV-1:0][SECT_W-1:0] DEV_SECT =
    {8'd135, 8'd71, 8'd39, 8'd23, 8'd128},
  parameter logic [NUM_DEV-1:0][4:0] DEV_LOG2 =
    {5'd23, 5'd22, 5'd21, 5'd20, 5'd23}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  output logic              busy,
  output logic              done,
  output logic [1:0]        family,
  output logic [7:0]        man_code,
  output logic [DATA_W-1:0] dev_code,
  output logic [SECT_W-1:0] sector_count,
  output logic [31:0]       bank_size
);
  logic              start_acc, cap_man, cap_dev, eval_now, finish, id_known;
  fam_e              fam_c, fam_q;
  logic [SECT_W-1:0] sect_c;
  logic [31:0]       size_c;

  probe_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SWAP_ADDR(SWAP_ADDR)) seq_i (
    .clk(clk), .rst_n(rst_n), .start(start), .bus_ack(bus_ack),
    .id_known(id_known), .fam_q(fam_q),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .start_acc(start_acc), .cap_man(cap_man), .cap_dev(cap_dev),
    .eval_now(eval_now), .finish(finish), .busy(busy)
  );

  probe_classify #(
    .DATA_W(DATA_W), .SECT_W(SECT_W), .NUM_DEV(NUM_DEV),
    .AMD_CODE(AMD_CODE), .INTEL_CODE(INTEL_CODE),
    .DEV_CODE(DEV_CODE), .DEV_SECT(DEV_SECT), .DEV_LOG2(DEV_LOG2)
  ) cls_i (
    .man_code(man_code), .dev_code(dev_code),
    .id_known(id_known), .fam_c(fam_c), .sect_c(sect_c), .size_c(size_c)
  );

  probe_result #(.DATA_W(DATA_W), .SECT_W(SECT_W)) res_i (
    .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .cap_man(cap_man),
    .cap_dev(cap_dev), .eval_now(eval_now), .finish(finish),
    .bus_rdata(bus_rdata), .fam_c(fam_c), .sect_c(sect_c), .size_c(size_c),
    .man_q(man_code), .dev_q(dev_code), .fam_q(fam_q),
    .sect_q(sector_count), .size_q(bank_size), .done_q(done)
  );

  assign family = fam_q;

endmodule

// File: tb/flash_id_probe_tb_top.sv
module flash_bus_model #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          we,
  input  logic          re,
  output logic [DW-1:0] rdata,
  output logic          ack,
  input  logic [DW-1:0] man_word,
  input  logic [DW-1:0] dev_word,
  input  logic [3:0]    delay
);
  logic [3:0] wait_cnt;
  int wr_n, rd_n;
  logic [AW-1:0] wr_a [8];
  logic [DW-1:0] wr_d [8];
  logic [AW-1:0] rd_a [8];

  assign rdata = (addr == AW'(1)) ? man_word : (addr == '0) ? dev_word : '1;

  task automatic clear_log();
    wr_n = 0;
    rd_n = 0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack <= 1'b0;
      wait_cnt <= '0;
    end else if (ack) begin
      ack <= 1'b0;
    end else if (we || re) begin
      if (wait_cnt == delay) begin
        ack <= 1'b1;
        wait_cnt <= '0;
        if (we) begin
          if (wr_n < 8) begin wr_a[wr_n] <= addr; wr_d[wr_n] <= wdata; end
          wr_n <= wr_n + 1;
        end else begin
          if (rd_n < 8) rd_a[rd_n] <= addr;
          rd_n <= rd_n + 1;
        end
      end else begin
        wait_cnt <= wait_cnt + 4'd1;
      end
    end
  end
endmodule

module flash_id_probe_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;

  // 16-bit bus instance
  logic        st_n;
  logic [11:0] a_n;
  logic [15:0] wd_n, rd_n, man_n, dev_n;
  logic        we_n, re_n, ack_n, busy_n, done_n;
  logic [1:0]  fam_n;
  logic [7:0]  mc_n, sc_n;
  logic [15:0] dc_n;
  logic [31:0] sz_n;
  logic [3:0]  dly_n;

  flash_id_probe dut_i (
    .clk(clk), .rst_n(rst_n), .start(st_n),
    .bus_addr(a_n), .bus_wdata(wd_n), .bus_we(we_n), .bus_re(re_n),
    .bus_rdata(rd_n), .bus_ack(ack_n), .busy(busy_n), .done(done_n),
    .family(fam_n), .man_code(mc_n), .dev_code(dc_n),
    .sector_count(sc_n), .bank_size(sz_n)
  );
  flash_bus_model #(.AW(12), .DW(16)) mdl_n (
    .clk(clk), .rst_n(rst_n), .addr(a_n), .wdata(wd_n), .we(we_n), .re(re_n),
    .rdata(rd_n), .ack(ack_n), .man_word(man_n), .dev_word(dev_n), .delay(dly_n)
  );

  // 32-bit bus, swapped unlock offsets
  logic        st_w;
  logic [11:0] a_w;
  logic [31:0] wd_w, rd_w, man_w, dev_w;
  logic        we_w, re_w, ack_w, busy_w, done_w;
  logic [1:0]  fam_w;
  logic [7:0]  mc_w, sc_w;
  logic [31:0] dc_w;
  logic [31:0] sz_w;

  flash_id_probe #(.DATA_W(32), .SWAP_ADDR(1'b1)) dut_w_i (
    .clk(clk), .rst_n(rst_n), .start(st_w),
    .bus_addr(a_w), .bus_wdata(wd_w), .bus_we(we_w), .bus_re(re_w),
    .bus_rdata(rd_w), .bus_ack(ack_w), .busy(busy_w), .done(done_w),
    .family(fam_w), .man_code(mc_w), .dev_code(dc_w),
    .sector_count(sc_w), .bank_size(sz_w)
  );
  flash_bus_model #(.AW(12), .DW(32)) mdl_w (
    .clk(clk), .rst_n(rst_n), .addr(a_w), .wdata(wd_w), .we(we_w), .re(re_w),
    .rdata(rd_w), .ack(ack_w), .man_word(man_w), .dev_word(dev_w), .delay(4'd1)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_n();
    @(negedge clk) st_n = 1'b1;
    @(negedge clk) st_n = 1'b0;
  endtask

  task automatic wait_done_n();
    for (int i = 0; i < 300 && !done_n; i++) @(negedge clk);
    chk("R9 done raised", done_n, 1'b1);
    chk("R9 busy low at done", busy_n, 1'b0);
  endtask

  task automatic run_n(input logic [15:0] man, input logic [15:0] dev, input logic [3:0] dly);
    man_n = man; dev_n = dev; dly_n = dly;
    mdl_n.clear_log();
    pulse_n();
    wait_done_n();
  endtask

  task automatic check_unlock_n();
    chk("R1 unlock1 addr", mdl_n.wr_a[0], 12'h555);
    chk("R1 unlock1 data", mdl_n.wr_d[0], 16'hAAAA);
    chk("R1 unlock2 addr", mdl_n.wr_a[1], 12'h2AA);
    chk("R1 unlock2 data", mdl_n.wr_d[1], 16'h5555);
    chk("R1 ident addr", mdl_n.wr_a[2], 12'h555);
    chk("R1 ident data", mdl_n.wr_d[2], 16'h9090);
    chk("R3 read count", mdl_n.rd_n, 2);
    chk("R3 man read offset", mdl_n.rd_a[0], 12'h001);
    chk("R3 dev read offset", mdl_n.rd_a[1], 12'h000);
  endtask

  task automatic t_reset();
    chk("R11 busy", busy_n, 1'b0);
    chk("R11 done", done_n, 1'b0);
    chk("R11 strobes", {we_n, re_n}, 2'b00);
    chk("R11 family", fam_n, 2'd0);
    chk("R11 sectors", sc_n, 8'd0);
    chk("R11 size", sz_n, 32'd0);
  endtask

  task automatic t_amd16();
    run_n(16'h0001, 16'h22D7, 4'd0);
    check_unlock_n();
    chk("R4 amd family", fam_n, 2'd1);
    chk("R5 amd sectors", sc_n, 8'd128);
    chk("R6 amd size 16-bit", sz_n, 32'h0080_0000);
    chk("R8 write count", mdl_n.wr_n, 4);
    chk("R8 exit addr", mdl_n.wr_a[3], 12'h000);
    chk("R8 amd exit data", mdl_n.wr_d[3], 16'hF0F0);
  endtask

  task automatic t_intel16_slow();
    run_n(16'h5A89, 16'h88C5, 4'd3);
    check_unlock_n();
    chk("R4 upper bits ignored", fam_n, 2'd2);
    chk("R2 slow ack sectors", sc_n, 8'd71);
    chk("R6 intel size", sz_n, 32'h0040_0000);
    chk("R2 write count slow ack", mdl_n.wr_n, 4);
    chk("R8 intel exit data", mdl_n.wr_d[3], 16'hFFFF);
  endtask

  task automatic t_unknown_man();
    run_n(16'h0020, 16'h22D7, 4'd1);
    check_unlock_n();
    chk("R7 unknown man family", fam_n, 2'd0);
    chk("R7 unknown man sectors", sc_n, 8'd0);
    chk("R7 unknown man size", sz_n, 32'd0);
    chk("R7 no exit write", mdl_n.wr_n, 3);
  endtask

  task automatic t_unknown_dev();
    run_n(16'h0089, 16'h00C5, 4'd0);
    chk("R5 partial code rejected", fam_n, 2'd0);
    chk("R7 unknown dev sectors", sc_n, 8'd0);
    chk("R7 unknown dev size", sz_n, 32'd0);
    chk("R7 unknown dev no exit write", mdl_n.wr_n, 3);
  endtask

  task automatic t_busy_start();
    man_n = 16'h0089; dev_n = 16'h88C1; dly_n = 4'd2;
    mdl_n.clear_log();
    pulse_n();
    repeat (4) @(negedge clk);
    pulse_n();
    repeat (6) @(negedge clk);
    pulse_n();
    wait_done_n();
    chk("R10 write count", mdl_n.wr_n, 4);
    chk("R10 read count", mdl_n.rd_n, 2);
    chk("R10 sectors", sc_n, 8'd23);
    chk("R10 size", sz_n, 32'h0010_0000);
  endtask

  task automatic t_done_hold();
    repeat (20) @(negedge clk);
    chk("R9 done held", done_n, 1'b1);
    chk("R9 sectors held", sc_n, 8'd23);
    chk("R9 no stray access", mdl_n.wr_n, 4);
    pulse_n();
    chk("R9 start clears done", done_n, 1'b0);
    chk("R9 busy after start", busy_n, 1'b1);
    wait_done_n();
  endtask

  task automatic run_w(input logic [31:0] man, input logic [31:0] dev);
    man_w = man; dev_w = dev;
    mdl_w.clear_log();
    @(negedge clk) st_w = 1'b1;
    @(negedge clk) st_w = 1'b0;
    for (int i = 0; i < 300 && !done_w; i++) @(negedge clk);
    chk("R9 wide done", done_w, 1'b1);
  endtask

  task automatic t_wide_intel();
    run_w(32'h0089_0089, 32'h88CD_88CD);
    chk("R1 swapped unlock1 addr", mdl_w.wr_a[0], 12'h554);
    chk("R1 wide unlock1 data", mdl_w.wr_d[0], 32'hAAAA_AAAA);
    chk("R1 swapped unlock2 addr", mdl_w.wr_a[1], 12'h2AB);
    chk("R1 wide unlock2 data", mdl_w.wr_d[1], 32'h5555_5555);
    chk("R1 swapped ident addr", mdl_w.wr_a[2], 12'h554);
    chk("R1 wide ident data", mdl_w.wr_d[2], 32'h9090_9090);
    chk("R5 wide sectors", sc_w, 8'd135);
    chk("R6 wide size doubled", sz_w, 32'h0100_0000);
    chk("R8 wide exit data", mdl_w.wr_d[3], 32'hFFFF_FFFF);
  endtask

  task automatic t_wide_half();
    run_w(32'h0001_0001, 32'h0000_88CD);
    chk("R5 half match rejected", fam_w, 2'd0);
    chk("R7 wide unknown size", sz_w, 32'd0);
    chk("R7 wide no exit write", mdl_w.wr_n, 3);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    st_n = 1'b0; st_w = 1'b0;
    man_n = '0; dev_n = '0; dly_n = '0;
    man_w = '0; dev_w = '0;
    mdl_n.clear_log();
    mdl_w.clear_log();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_amd16();
    t_intel16_slow();
    t_unknown_man();
    t_unknown_dev();
    t_busy_start();
    t_done_hold();
    t_wide_intel();
    t_wide_half();
    finish_run();
  end
endmodule